// File: doc/BRIEF.md
# Event Frame Wrapper with Running CRC-16

This block turns a stream of 64-bit payload words into a complete event frame. It emits one header word, then the payload words unchanged and in order, then one trailer word. The header carries a start marker, a format version, a trigger number, a bunch-crossing number, a source identifier and an event type. The trailer carries an end marker, the frame length counted in 64-bit words, a status byte and a 16-bit CRC. The CRC is accumulated as each word leaves, so no word is ever stored.

The sideband fields (trigger, bunch, source, type and status) are captured once per event. For an event with payload, capture happens when the first payload word is presented in idle. For an event with no payload, capture happens on a one-cycle empty-event request. Output back-pressure passes straight back to the payload input, and there is no buffering in the frame path.

The controller has four states:
- `ST_IDLE` waits for a payload word or an empty-event request and moves to `ST_HEAD`.
- `ST_HEAD` drives the header. When the header is accepted it moves to `ST_BODY`, or to `ST_TAIL` if the event is empty.
- `ST_BODY` forwards payload words and moves to `ST_TAIL` when the word marked last is accepted.
- `ST_TAIL` drives the trailer and returns to `ST_IDLE` when the trailer is accepted.

Top module: `evt_framer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `m_valid` and `s_ready` are 0. A reset in the middle of an event returns the block to idle.
- R2: The first word of each frame is the header:
  - bits [63:60] hold the start marker (default 4'h5);
  - bits [59:56] hold the format version (default 4'h1);
  - bits [55:32] hold the trigger number;
  - bits [31:20] hold the bunch number;
  - bits [19:8] hold the source identifier;
  - bits [7:4] hold the event type;
  - bits [3:0] are 0.
- R3: The payload words follow the header unchanged and in input order, with `m_last` 0 on each of them.
- R4: The last word of each frame is the trailer, and it is the only word with `m_last` 1. Its layout:
  - bits [63:60] hold the end marker (default 4'hA);
  - bits [59:56] are 0;
  - bits [55:32] hold the length;
  - bits [31:24] hold the status;
  - bits [23:16] are 0;
  - bits [15:0] hold the CRC.
- R5: The length field equals the number of payload words plus 2, so it counts the header and the trailer as well.
- R6: The CRC uses polynomial 0x1021 with initial value 0xFFFF. It runs over all 64 bits of the header and then of each payload word, MSB first. The trailer is not included.
- R7: An empty-event request in idle, with no payload word presented, produces a frame of exactly two words: header then trailer, with length 2.
- R8: Sideband values are taken only at event start. Changes to them later in the event do not affect the header or the trailer.
- R9: `s_ready` is never 1 while `m_ready` is 0. No word is lost or repeated under any back-pressure pattern.
- R10: After the trailer is accepted, `m_valid` is 0 for at least one cycle before the next frame starts.
- R11: An empty-event request that arrives while a frame is in progress is ignored. No extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Payload word valid |
| s_ready | output | 1 | Payload word accepted when high together with `s_valid` |
| s_data | input | 64 | Payload word |
| s_last | input | 1 | Marks the last payload word of the event |
| empty_req | input | 1 | One-cycle request for an event with no payload |
| sb_trig | input | 24 | Trigger number |
| sb_bunch | input | 12 | Bunch number |
| sb_src | input | 12 | Source identifier |
| sb_etype | input | 4 | Event type |
| sb_status | input | 8 | Event status byte |
| m_valid | output | 1 | Frame word valid |
| m_ready | input | 1 | Downstream accepts the frame word |
| m_data | output | 64 | Frame word |
| m_last | output | 1 | High on the trailer word only |

## Verification
The checker watches several local relations on every cycle:
- the trailer's marker and zero bits, and that its length is at least 2;
- that each accepted payload word appears on the output unchanged;
- that input ready never runs ahead of output ready;
- that a stalled output word is held steady;
- that an idle gap follows every trailer.

Several properties span a whole event, and only the bench's scenarios can show them:
- that the CRC value and the exact length match the payload;
- that sideband fields changed after capture leave the frame untouched;
- that a stray empty-event request mid-frame does not create an extra frame.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;

    localparam int WORD_W  = 64;
    localparam int LEN_W   = 24;
    localparam int CRC_W   = 16;
    localparam int TRIG_W  = 24;
    localparam int BUNCH_W = 12;
    localparam int SRC_W   = 12;
    localparam int TYPE_W  = 4;
    localparam int STAT_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL
    } fr_state_e;

    typedef struct packed {
        logic [TRIG_W-1:0]  trig;
        logic [BUNCH_W-1:0] bunch;
        logic [SRC_W-1:0]   src;
        logic [TYPE_W-1:0]  etype;
        logic [STAT_W-1:0]  status;
    } evt_side_t;

    function automatic logic [WORD_W-1:0] pack_head(
        input logic [3:0] marker,
        input logic [3:0] version,
        input evt_side_t  side
    );
        return {marker, version, side.trig, side.bunch, side.src, side.etype, 4'h0};
    endfunction

    function automatic logic [WORD_W-1:0] pack_tail(
        input logic [3:0]        marker,
        input logic [LEN_W-1:0]  len,
        input logic [STAT_W-1:0] status,
        input logic [CRC_W-1:0]  crc
    );
        return {marker, 4'h0, len, status, 8'h00, crc};
    endfunction

endpackage

// File: rtl/evt_crc_step.sv
module evt_crc_step #(
    parameter int             DATA_W = 64,
    parameter int             CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] stage [0:DATA_W];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][CRC_W-1] ^ data[DATA_W-1-i];
        assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DATA_W];

endmodule

// File: rtl/evt_len_cnt.sv
module evt_len_cnt #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/evt_framer.sv
module evt_framer
    import evt_framer_pkg::*;
#(
    parameter logic [3:0]       HEAD_MARK = 4'h5,
    parameter logic [3:0]       TAIL_MARK = 4'hA,
    parameter logic [3:0]       FMT_VER   = 4'h1,
    parameter logic [15:0]      CRC_POLY  = 16'h1021,
    parameter logic [15:0]      CRC_INIT  = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_valid,
    output logic        s_ready,
    input  logic [63:0] s_data,
    input  logic        s_last,
    input  logic        empty_req,
    input  logic [23:0] sb_trig,
    input  logic [11:0] sb_bunch,
    input  logic [11:0] sb_src,
    input  logic [3:0]  sb_etype,
    input  logic [7:0]  sb_status,
    output logic        m_valid,
    input  logic        m_ready,
    output logic [63:0] m_data,
    output logic        m_last
);

    fr_state_e          state_q, state_d;
    evt_side_t          side_q;
    logic               empty_q;
    logic [CRC_W-1:0]   crc_q, crc_nxt;
    logic [LEN_W-1:0]   len_cnt;
    logic [WORD_W-1:0]  head_word, tail_word;
    logic               start_evt, word_fire, count_fire;

    assign start_evt  = (state_q == ST_IDLE) && (s_valid || empty_req);
    assign word_fire  = m_valid && m_ready;
    assign count_fire = word_fire && (state_q == ST_HEAD || state_q == ST_BODY);

    assign head_word = pack_head(HEAD_MARK, FMT_VER, side_q);
    assign tail_word = pack_tail(TAIL_MARK, len_cnt + 1'b1, side_q.status, crc_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (s_valid || empty_req)            state_d = ST_HEAD;
            ST_HEAD: if (m_ready)                         state_d = empty_q ? ST_TAIL : ST_BODY;
            ST_BODY: if (s_valid && m_ready && s_last)    state_d = ST_TAIL;
            ST_TAIL: if (m_ready)                         state_d = ST_IDLE;
            default:                                      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        m_valid = 1'b0;
        m_data  = '0;
        m_last  = 1'b0;
        s_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HEAD: begin
                m_valid = 1'b1;
                m_data  = head_word;
            end
            ST_BODY: begin
                m_valid = s_valid;
                m_data  = s_data;
                s_ready = m_ready;
            end
            ST_TAIL: begin
                m_valid = 1'b1;
                m_data  = tail_word;
                m_last  = 1'b1;
            end
            default: ;
        endcase
    end

    // Sideband capture and running CRC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            side_q  <= '0;
            empty_q <= 1'b0;
            crc_q   <= CRC_INIT;
        end else if (start_evt) begin
            side_q  <= '{trig: sb_trig, bunch: sb_bunch, src: sb_src,
                         etype: sb_etype, status: sb_status};
            empty_q <= !s_valid;
            crc_q   <= CRC_INIT;
        end else if (count_fire) begin
            crc_q   <= crc_nxt;
        end
    end

    evt_crc_step #(
        .DATA_W (WORD_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY)
    ) u_crc (
        .crc_in  (crc_q),
        .data    (m_data),
        .crc_out (crc_nxt)
    );

    evt_len_cnt #(
        .LEN_W (LEN_W)
    ) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_evt),
        .inc   (count_fire),
        .cnt   (len_cnt)
    );

endmodule

// File: rtl/evt_framer_chk.sv
module evt_framer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        s_valid,
    input logic        s_ready,
    input logic [63:0] s_data,
    input logic        s_last,
    input logic        m_valid,
    input logic        m_ready,
    input logic [63:0] m_data,
    input logic        m_last
);

    assert_tail_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last) |-> (m_data[63:60] == 4'hA && m_data[59:56] == 4'h0 && m_data[23:16] == 8'h00));

    assert_min_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last) |-> (m_data[55:32] >= 24'd2));

    assert_body_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> (m_valid && !m_last && m_data == s_data));

    assert_no_early_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> m_ready);

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    assert_gap_after_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> !m_valid);

    logic unused_ok;
    assign unused_ok = s_last;

endmodule

bind evt_framer evt_framer_chk u_chk (.*);

// File: tb/sim_evt_framer.sv
`timescale 1ns/1ps
module sim_evt_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_ready, s_last = 1'b0, empty_req = 1'b0;
    logic [63:0] s_data = '0;
    logic [23:0] sb_trig = '0;
    logic [11:0] sb_bunch = '0, sb_src = '0;
    logic [3:0]  sb_etype = '0;
    logic [7:0]  sb_status = '0;
    logic        m_valid, m_ready = 1'b1, m_last;
    logic [63:0] m_data;

    int total = 0, bad = 0;
    int rmode = 0, cyc = 0;
    logic [63:0] got [0:255];
    logic        got_last [0:255];
    int          got_n = 0;
    bit          prev_last = 0;
    bit          finished = 0;

    localparam int NEV = 6;
    localparam int EV_N    [NEV] = '{1, 3, 0, 8, 2, 5};
    localparam int EV_MODE [NEV] = '{0, 1, 0, 2, 1, 2};

    evt_framer u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .empty_req(empty_req),
        .sb_trig(sb_trig), .sb_bunch(sb_bunch), .sb_src(sb_src),
        .sb_etype(sb_etype), .sb_status(sb_status),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [63:0] d);
        logic [15:0] r = c;
        for (int i = 63; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [63:0] pay_word(input int idx, input int k);
        return 64'hA5C3_0000_0000_0000 ^ (64'(idx) << 40) ^ (64'(k) * 64'h0001_0203_0405_0607);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Downstream ready patterns
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        case (rmode)
            0:       m_ready = 1'b1;
            1:       m_ready = cyc[0];
            default: m_ready = (cyc % 3 == 0);
        endcase
    end

    // Output monitor, sampled mid-cycle
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (!m_ready && s_ready) check(0, "R9 s_ready while m_ready low", 64'(s_ready), 64'd0);
            if (prev_last) check(!m_valid, "R10 gap after trailer", 64'(m_valid), 64'd0);
            prev_last = 0;
            if (m_valid && m_ready) begin
                got[got_n[7:0]]      = m_data;
                got_last[got_n[7:0]] = m_last;
                got_n++;
                prev_last = m_last;
            end
        end else begin
            prev_last = 0;
        end
    end

    task automatic scramble_side();
        sb_trig = 24'hFFFFFF; sb_bunch = 12'hFFF; sb_src = 12'hFFF;
        sb_etype = 4'hF; sb_status = 8'hFF;
    endtask

    task automatic send_event(input int n, input int idx);
        logic [23:0] trig = 24'h0A0000 + 24'(idx * 'h111);
        logic [11:0] bx   = 12'h100 + 12'(idx);
        logic [11:0] src  = 12'h2C0 + 12'(idx * 3);
        logic [3:0]  typ  = 4'(idx + 1);
        logic [7:0]  st   = 8'h30 + 8'(idx);
        logic [63:0] eh, t;
        logic [15:0] crc;
        int base = got_n;
        int waitc;
        bit last_ok;
        sb_trig = trig; sb_bunch = bx; sb_src = src; sb_etype = typ; sb_status = st;
        if (n == 0) begin
            empty_req = 1'b1;
            @(posedge clk); #1;
            empty_req = 1'b0;
            scramble_side();
        end else begin
            for (int k = 0; k < n; k++) begin
                s_valid = 1'b1;
                s_data  = pay_word(idx, k);
                s_last  = (k == n - 1);
                if (k == 0) begin
                    @(posedge clk); #1;
                    scramble_side();
                end
                if (k == 4) empty_req = 1'b1;   // R11 stray request mid-frame
                forever begin
                    @(negedge clk);
                    if (s_ready) break;
                end
                @(posedge clk); #1;
                empty_req = 1'b0;
            end
            s_valid = 1'b0; s_last = 1'b0;
        end
        waitc = 0;
        while (got_n < base + n + 2 && waitc < 2000) begin
            @(posedge clk); waitc++;
        end
        #1;
        check(got_n - base == n + 2, "R5 word count", 64'(got_n - base), 64'(n + 2));
        eh = {4'h5, 4'h1, trig, bx, src, typ, 4'h0};
        check(got[base[7:0]] == eh, "R2 R8 header", got[base[7:0]], eh);
        crc = ref_crc(16'hFFFF, eh);
        last_ok = !got_last[base[7:0]];
        for (int k = 0; k < n; k++) begin
            check(got[8'(base + 1 + k)] == pay_word(idx, k), "R3 payload", got[8'(base + 1 + k)], pay_word(idx, k));
            last_ok = last_ok && !got_last[8'(base + 1 + k)];
            crc = ref_crc(crc, pay_word(idx, k));
        end
        t = got[8'(base + n + 1)];
        check(last_ok && got_last[8'(base + n + 1)], "R4 last only on trailer", 64'(got_last[8'(base + n + 1)]), 64'd1);
        check(t[63:60] == 4'hA && t[59:56] == 4'h0 && t[23:16] == 8'h00, "R4 trailer marker", t, 64'hA000_0000_0000_0000);
        check(t[55:32] == 24'(n + 2), "R5 length", 64'(t[55:32]), 64'(n + 2));
        check(t[31:24] == st, "R8 status", 64'(t[31:24]), 64'(st));
        check(t[15:0] == crc, "R6 crc", 64'(t[15:0]), 64'(crc));
        if (n == 0) check(got_n - base == 2, "R7 empty frame", 64'(got_n - base), 64'd2);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            check(0, "watchdog", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!m_valid && !s_ready, "R1 in reset", {m_valid, s_ready}, 64'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!m_valid && !s_ready, "R1 after reset", {m_valid, s_ready}, 64'd0);

        for (int i = 0; i < NEV; i++) begin
            rmode = EV_MODE[i];
            send_event(EV_N[i], i);
            repeat (2) @(posedge clk);
            #1;
        end

        // R11: no spurious frame after a stray mid-frame request
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            check(!m_valid, "R11 idle stays idle", 64'(m_valid), 64'd0);
        end

        // R1: reset in the middle of a frame
        @(posedge clk); #1;
        rmode = 0;
        s_valid = 1'b1; s_data = 64'h1; s_last = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b0;
        s_valid = 1'b0;
        #1;
        check(!m_valid && !s_ready, "R1 mid-frame reset", {m_valid, s_ready}, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!m_valid, "R1 idle after reset", 64'(m_valid), 64'd0);
        send_event(4, 9);
        send_event(0, 10);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule